// File: doc/BRIEF.md
# Oversampled SPI Slave Byte Port

This block is an SPI slave that lives entirely in the fast system clock domain. Chip select, the serial clock and the master-out data line enter as ordinary inputs. Each passes through a synchroniser, and the serial clock's edges are found by comparing successive samples. The system clock must run at roughly ten times the serial clock or faster.

Toward internal logic the block offers two byte handshakes. On the receive side, each completed byte appears on a parallel output together with a flag. That flag stays high for a fixed number of system cycles, so a slower controller can wait for it to drop. On the transmit side, a rising send request loads a byte. The block holds a busy flag while it shifts that byte out on the master-in line during the next frame.

The serial mode is fixed. The clock idles low, the slave samples on the rising edge and the slave drives on the falling edge, most significant bit first in both directions.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, rx_valid_o, tx_busy_o and miso_o are 0 and rx_data_o is 0x00.
- R2: While cs_ni is low, every rising edge of sck_i shifts mosi_i into the receiver, most significant bit first. After the eighth bit, rx_data_o holds the whole byte.
- R3: rx_valid_o rises on the third system clock edge after the eighth sck_i rise (with SYNC_STAGES = 2). It stays high for exactly RX_FLAG_CYCLES cycles.
- R4: sck_i edges while cs_ni is high are ignored: rx_valid_o does not rise and rx_data_o keeps its value.
- R5: A rising edge of send_req_i while tx_busy_o is low loads send_data_i. tx_busy_o is high on the next cycle, and miso_o shows bit 7 of the loaded byte at once.
- R6: miso_o moves to the next lower bit only on a falling sck_i edge that follows at least one rising edge since the load. The master therefore reads the loaded byte MSB first at its eight rising edges.
- R7: tx_busy_o falls on the third system clock edge after the eighth sck_i rise following the load.
- R8: Only a rising edge of send_req_i loads a byte. Holding send_req_i high causes no second load after the byte is done. A rising edge while tx_busy_o is high is ignored.
- R9: Raising cs_ni mid-byte discards the partial received byte and resets both bit counts. It also clears tx_busy_o, so miso_o returns to 0.
- R10: While no byte is loaded, miso_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select from master, active low |
| sck_i | input | 1 | Serial clock from master, idles low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| rx_data_o | output | DATA_W | Last completed received byte |
| rx_valid_o | output | 1 | Received-byte flag, stretched |
| send_req_i | input | 1 | Transmit request, acts on its rising edge |
| send_data_i | input | DATA_W | Byte to transmit |
| tx_busy_o | output | 1 | Loaded byte not yet fully shifted out |

## Verification
The bench builds the block with its defaults: DATA_W = 8, SYNC_STAGES = 2 and RX_FLAG_CYCLES = 4. It drives the serial clock with an eight-cycle half period. The two-stage synchroniser fixes the output latency at three clock edges, so the bench can sample the rise and fall of the receive flag and the busy flag on exact cycles. The short flag stretch lets the whole flag window be observed between two serial edges, and it leaves room to probe mid-byte aborts and overlapping requests.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    // Decoded view of the synchronised serial pins, one system cycle wide
    typedef struct packed {
        logic mosi;    // synchronised data line
        logic cs_n;    // synchronised select level
        logic rise;    // serial clock went low -> high
        logic fall;    // serial clock went high -> low
        logic cs_end;  // select went low -> high
    } spi_line_t;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int unsigned          WIDTH   = 1,
    parameter int unsigned          STAGES  = 2,
    parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    if (STAGES == 0) begin : g_bypass
        assign q_o = d_i;
    end else begin : g_chain
        logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

        always_comb begin
            chain_d[0] = d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_d[i] = chain_q[i-1];
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= {STAGES{RST_VAL}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign q_o = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_port_front.sv
module spi_port_front
    import spi_port_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      cs_ni,
    input  logic      sck_i,
    input  logic      mosi_i,
    output spi_line_t line_o
);

    localparam int unsigned PIN_W = 3;
    localparam int unsigned CS_B  = 2;
    localparam int unsigned SCK_B = 1;
    localparam int unsigned DAT_B = 0;

    typedef struct packed {
        logic sck;
        logic cs_n;
    } prev_t;

    logic [PIN_W-1:0] raw_pins;
    logic [PIN_W-1:0] sync_pins;
    prev_t            prev_d, prev_q;

    assign raw_pins = {cs_ni, sck_i, mosi_i};

    spi_port_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_pins),
        .q_o    (sync_pins)
    );

    always_comb begin
        prev_d.sck  = sync_pins[SCK_B];
        prev_d.cs_n = sync_pins[CS_B];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '{sck: 1'b0, cs_n: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    always_comb begin
        line_o.mosi   = sync_pins[DAT_B];
        line_o.cs_n   = sync_pins[CS_B];
        line_o.rise   = sync_pins[SCK_B] & ~prev_q.sck;
        line_o.fall   = ~sync_pins[SCK_B] & prev_q.sck;
        line_o.cs_end = sync_pins[CS_B] & ~prev_q.cs_n;
    end

endmodule

// File: rtl/spi_port_rx.sv
module spi_port_rx
    import spi_port_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned FLAG_CYCLES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  spi_line_t         line_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o
);

    localparam int unsigned         BIT_W     = $clog2(DATA_W);
    localparam int unsigned         HOLD_W    = $clog2(FLAG_CYCLES + 1);
    localparam logic [BIT_W-1:0]    LAST_BIT  = BIT_W'(DATA_W - 1);
    localparam logic [HOLD_W-1:0]   HOLD_INIT = HOLD_W'(FLAG_CYCLES - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shift;
        logic [BIT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic [HOLD_W-1:0] hold;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic [DATA_W-1:0] shifted;

    assign shifted = {s_q.shift[DATA_W-2:0], line_i.mosi};

    always_comb begin
        s_d = s_q;
        // flag stretch countdown
        if (s_q.valid) begin
            if (s_q.hold == '0) begin
                s_d.valid = 1'b0;
            end else begin
                s_d.hold = s_q.hold - HOLD_W'(1);
            end
        end
        // serial capture
        if (line_i.cs_n) begin
            s_d.shift   = '0;
            s_d.bit_cnt = '0;
        end else if (line_i.rise) begin
            s_d.shift = shifted;
            if (s_q.bit_cnt == LAST_BIT) begin
                s_d.bit_cnt = '0;
                s_d.data    = shifted;
                s_d.valid   = 1'b1;
                s_d.hold    = HOLD_INIT;
            end else begin
                s_d.bit_cnt = s_q.bit_cnt + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_data_o  = s_q.data;
    assign rx_valid_o = s_q.valid;

    // R2
    rx_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.valid) |-> ($past(line_i.rise) && !$past(line_i.cs_n)));

    // R3
    rx_flag_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(s_q.valid) |-> ($past(s_q.hold) == '0));

    // R9
    rx_cs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_i.cs_n |=> (s_q.bit_cnt == '0));

endmodule

// File: rtl/spi_port_tx.sv
module spi_port_tx
    import spi_port_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  spi_line_t         line_i,
    input  logic              send_req_i,
    input  logic [DATA_W-1:0] send_data_i,
    output logic              miso_o,
    output logic              tx_busy_o
);

    localparam int unsigned      BIT_W    = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shift;
        logic [BIT_W-1:0]  rise_cnt;
        logic              busy;
        logic              req_prev;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic      req_rise;
    logic      active;

    assign req_rise = send_req_i & ~s_q.req_prev;
    assign active   = ~line_i.cs_n;

    always_comb begin
        s_d          = s_q;
        s_d.req_prev = send_req_i;
        if (line_i.cs_end) begin
            s_d.busy     = 1'b0;
            s_d.rise_cnt = '0;
        end else if (s_q.busy) begin
            if (active && line_i.rise) begin
                if (s_q.rise_cnt == LAST_BIT) begin
                    s_d.busy     = 1'b0;
                    s_d.rise_cnt = '0;
                end else begin
                    s_d.rise_cnt = s_q.rise_cnt + BIT_W'(1);
                end
            end else if (active && line_i.fall && (s_q.rise_cnt != '0)) begin
                s_d.shift = {s_q.shift[DATA_W-2:0], 1'b0};
            end
        end else if (req_rise) begin
            s_d.busy     = 1'b1;
            s_d.shift    = send_data_i;
            s_d.rise_cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso_o    = s_q.busy ? s_q.shift[DATA_W-1] : 1'b0;
    assign tx_busy_o = s_q.busy;

    // R5
    tx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (send_req_i && !s_q.req_prev && !s_q.busy && !line_i.cs_end)
        |=> (s_q.busy && (miso_o == $past(send_data_i[DATA_W-1]))));

    // R8
    tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && !line_i.fall) |=> (s_q.shift == $past(s_q.shift)));

    // R7
    tx_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(s_q.busy) |-> ($past(line_i.cs_end) || $past(line_i.rise)));

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_port_pkg::*;
#(
    parameter int unsigned DATA_W         = 8,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned RX_FLAG_CYCLES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_ni,
    input  logic              sck_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              send_req_i,
    input  logic [DATA_W-1:0] send_data_i,
    output logic              tx_busy_o
);

    spi_line_t line;

    spi_port_front #(
        .STAGES (SYNC_STAGES)
    ) u_front (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cs_ni  (cs_ni),
        .sck_i  (sck_i),
        .mosi_i (mosi_i),
        .line_o (line)
    );

    spi_port_rx #(
        .DATA_W      (DATA_W),
        .FLAG_CYCLES (RX_FLAG_CYCLES)
    ) u_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .line_i     (line),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o)
    );

    spi_port_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .line_i      (line),
        .send_req_i  (send_req_i),
        .send_data_i (send_data_i),
        .miso_o      (miso_o),
        .tx_busy_o   (tx_busy_o)
    );

endmodule

// File: tb/spi_byte_port_tb.sv
module spi_byte_port_tb;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       send_req = 1'b0;
    logic [7:0] send_data = 8'h00;
    logic       tx_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_byte_port u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cs_ni       (cs_n),
        .sck_i       (sck),
        .mosi_i      (mosi),
        .miso_o      (miso),
        .rx_data_o   (rx_data),
        .rx_valid_o  (rx_valid),
        .send_req_i  (send_req),
        .send_data_i (send_data),
        .tx_busy_o   (tx_busy)
    );

    // mosi byte, expected miso byte
    localparam logic [15:0] VEC [0:5] = '{
        16'hA53C, 16'h0081, 16'hFF00, 16'h5AC3, 16'h18E7, 16'h7F80
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Shift nbits of b (from bit 7 down). Returns miso captured before each
    // rise, and rx flag/data three edges after the last rise.
    task automatic xfer(input logic [7:0] b, input int nbits,
                        output logic [7:0] cap, output logic rxv, output logic [7:0] rxd);
        cap = 8'h00;
        rxv = 1'b0;
        rxd = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            tick(HALF);
            cap[i] = miso;
            sck = 1'b1;
            tick(3);
            rxv = rx_valid;
            rxd = rx_data;
            tick(HALF - 3);
            sck = 1'b0;
        end
    endtask

    task automatic load(input logic [7:0] d);
        send_data = d;
        send_req = 1'b1;
        tick(2);
        send_req = 1'b0;
        tick(1);
    endtask

    initial begin
        logic [7:0] cap;
        logic       rxv;
        logic [7:0] rxd;

        // R1 reset state
        tick(3);
        check("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R1 tx_busy", {31'd0, tx_busy}, 32'd0);
        check("R1 miso", {31'd0, miso}, 32'd0);
        check("R1 rx_data", {24'd0, rx_data}, 32'd0);
        rst_n = 1'b1;
        tick(3);

        // table walk: R2 R5 R6 R7 R3
        for (int v = 0; v < 6; v++) begin
            load(VEC[v][7:0]);
            check("R5 busy after load", {31'd0, tx_busy}, 32'd1);
            check("R5 miso msb at load", {31'd0, miso}, {31'd0, VEC[v][7]});
            cs_n = 1'b0;
            tick(HALF);
            xfer(VEC[v][15:8], 8, cap, rxv, rxd);
            check("R3 rx_valid raised", {31'd0, rxv}, 32'd1);
            check("R2 rx byte", {24'd0, rxd}, {24'd0, VEC[v][15:8]});
            check("R6 miso byte", {24'd0, cap}, {24'd0, VEC[v][7:0]});
            check("R7 busy cleared", {31'd0, tx_busy}, 32'd0);
            cs_n = 1'b1;
            tick(HALF);
        end

        // R3 exact flag window, R10 idle miso
        cs_n = 1'b0;
        tick(HALF);
        xfer(8'hC6, 7, cap, rxv, rxd);
        check("R10 idle miso zeros", {24'd0, cap}, 32'd0);
        mosi = 1'b0;
        tick(HALF);
        sck = 1'b1;
        tick(1); check("R3 edge1 low", {31'd0, rx_valid}, 32'd0);
        tick(1); check("R3 edge2 low", {31'd0, rx_valid}, 32'd0);
        tick(1); check("R3 edge3 high", {31'd0, rx_valid}, 32'd1);
        check("R2 flag byte", {24'd0, rx_data}, 32'hC6);
        tick(3); check("R3 edge6 high", {31'd0, rx_valid}, 32'd1);
        tick(1); check("R3 edge7 low", {31'd0, rx_valid}, 32'd0);
        tick(HALF - 7);
        sck = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);

        // R4 clocks with select high are ignored
        xfer(8'hFF, 8, cap, rxv, rxd);
        check("R4 no flag", {31'd0, rxv}, 32'd0);
        check("R4 data kept", {24'd0, rx_data}, 32'hC6);

        // R9 abort mid-byte
        load(8'hFF);
        cs_n = 1'b0;
        tick(HALF);
        xfer(8'hF0, 4, cap, rxv, rxd);
        cs_n = 1'b1;
        tick(4);
        check("R9 busy cleared", {31'd0, tx_busy}, 32'd0);
        check("R9 miso zero", {31'd0, miso}, 32'd0);
        cs_n = 1'b0;
        tick(HALF);
        xfer(8'h5A, 8, cap, rxv, rxd);
        check("R9 clean byte", {24'd0, rxd}, 32'h5A);
        check("R10 miso zero after abort", {24'd0, cap}, 32'd0);
        cs_n = 1'b1;
        tick(HALF);

        // R8 held request loads once
        send_data = 8'hC3;
        send_req = 1'b1;
        tick(3);
        cs_n = 1'b0;
        tick(HALF);
        xfer(8'h00, 8, cap, rxv, rxd);
        check("R8 held req byte", {24'd0, cap}, 32'hC3);
        tick(4);
        check("R8 no reload while held", {31'd0, tx_busy}, 32'd0);
        cs_n = 1'b1;
        send_req = 1'b0;
        tick(HALF);

        // R8 request while busy ignored
        load(8'h81);
        load(8'h7E);
        cs_n = 1'b0;
        tick(HALF);
        xfer(8'h00, 8, cap, rxv, rxd);
        check("R8 busy req ignored", {24'd0, cap}, 32'h81);
        cs_n = 1'b1;
        tick(HALF);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule